// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block carries out the two halves of an optimistic atomic update for a single hart: a load-reserved (LR) that reads a word and opens a reservation, and a store-conditional (SC) that writes a word only when that reservation is still intact. It holds a small private word memory and a single reservation over an aligned granule. It accepts one decoded request per cycle: the instruction word, the byte address taken from the base register, and the store word. It answers one cycle later with a result value, the destination register tag and an error flag.

Other agents report their stores on a snoop port. A snooped store into the reserved granule cancels the reservation at once. Nothing stalls and nothing locks a shared path: a store-conditional that loses the race simply reports failure, and software retries. Every store-conditional that is decoded and word-aligned consumes the reservation, whether it commits or not.

Top module: `lrsc_monitor`

## Requirements
- R1: A request is legal only when opcode bits [6:0] are 7'b0101111 and width bits [14:12] are 3'b010. An LR also needs bits [31:27] = 5'b00010 and bits [24:20] = 0. An SC needs bits [31:27] = 5'b00011. Any other word gives rsp_err = 1 and rsp_data = 0, and it changes neither memory nor the reservation.
- R2: Each cycle with req_valid high produces rsp_valid high in the following cycle, with rsp_rd equal to bits [11:7] of the request. rsp_valid is low in every other cycle.
- R3: An aligned LR returns the addressed memory word, sign-extended from bit 31 to XLEN bits.
- R4: An aligned LR reserves the 8-byte granule holding its address. An aligned SC to any word of a still-reserved granule writes its store word and returns 0.
- R5: An aligned SC made with no reservation, or to a different granule, returns 1 and leaves memory unchanged.
- R6: Every aligned SC clears the reservation, so a second SC right after a successful one fails.
- R7: A snooped store whose address lies in the reserved granule clears the reservation. A snooped store to another granule leaves it in place.
- R8: A snoop into the reserved granule in the same cycle as an SC to that granule makes the SC fail.
- R9: A new LR replaces the old reservation, so an SC to the earlier granule then fails.
- R10: An LR or SC whose address has bit 1 or bit 0 set gives rsp_err = 1, with rsp_data = 0 for LR and 1 for SC. It leaves memory and the reservation untouched.
- R11: After reset, rsp_valid is low, no reservation is held and every memory word reads as zero.
- R12: A snoop in the same cycle as an LR, falling in that LR's granule, leaves no reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_insn | input | 32 | Instruction word to decode |
| req_addr | input | AW (6) | Byte address from the base register |
| req_wdata | input | 32 | Store word for SC |
| snoop_valid | input | 1 | Another agent stores this cycle |
| snoop_addr | input | AW (6) | Byte address of that store |
| rsp_valid | output | 1 | Result present, one cycle after the request |
| rsp_rd | output | 5 | Destination register tag |
| rsp_data | output | XLEN (64) | LR data, or SC status (0 = committed, 1 = failed) |
| rsp_err | output | 1 | Illegal encoding or misaligned address |

## Verification
The LR/SC pair is tried with clean reserve-then-commit pairs and with SCs to a different word of the same granule. It is also tried against a foreign granule, against a cold reservation and against a reservation already consumed; these patterns tell the granule compare apart from the valid bit. Snoops are placed before an SC and in the same cycle as an SC or an LR, both inside and outside the granule. This shows whether the cancel path takes priority over the commit path. Misaligned and malformed words separate the error path from the reservation path. A long seeded random mix over a few granules then compares every response against a bench model of memory and reservation.

// File: rtl/lrsc_pkg.sv
// Shared definitions for the LR/SC monitor: operation kinds and
// the fixed instruction-field encodings it recognises.
package lrsc_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LR   = 2'd1,
        OP_SC   = 2'd2,
        OP_BAD  = 2'd3
    } lrsc_op_e;

    localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
    localparam logic [2:0] WIDTH_WORD = 3'b010;
    localparam logic [4:0] KIND_LR    = 5'b00010;
    localparam logic [4:0] KIND_SC    = 5'b00011;

endpackage

// File: rtl/lrsc_decode.sv
// Instruction classifier.
// Turns the fields of a request word into LR, SC, illegal or none.
// Assumes the caller slices the fields; the ordering bits and the
// base-register field do not affect the classification.
module lrsc_decode
    import lrsc_pkg::*;
(
    input  logic       valid,
    input  logic [4:0] kind,
    input  logic [4:0] src2,
    input  logic [2:0] width,
    input  logic [6:0] opcode,
    output lrsc_op_e   op
);

    // Classify the request from its major opcode, width and kind fields
    always_comb begin
        op = OP_NONE;
        if (valid) begin
            op = OP_BAD;
            if (opcode == OPC_ATOMIC && width == WIDTH_WORD) begin
                if (kind == KIND_LR && src2 == 5'd0) begin
                    op = OP_LR;
                end else if (kind == KIND_SC) begin
                    op = OP_SC;
                end
            end
        end
    end

endmodule

// File: rtl/lrsc_resv.sv
// Single reservation register over an aligned granule.
// Tracks one valid bit and the granule tag. It reports whether
// the granule of chk_addr is still covered this cycle, taking a
// same-cycle snoop hit into account. A set wins over a clear.
module lrsc_resv #(
    parameter int AW  = 6,
    parameter int GL2 = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic          clear,
    input  logic [AW-1:0] addr,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    output logic          covers,
    output logic          vld_q,
    output logic [AW-GL2-1:0] tag_q
);

    localparam int TW = AW - GL2;

    logic [TW-1:0] req_tag;
    logic [TW-1:0] snp_tag;
    logic          snp_hit_cur;
    logic          snp_hit_new;

    // Granule tags of the request and of the snooped store
    always_comb begin
        req_tag     = addr[AW-1:GL2];
        snp_tag     = snoop_addr[AW-1:GL2];
        snp_hit_cur = snoop_valid && vld_q && (snp_tag == tag_q);
        snp_hit_new = snoop_valid && (snp_tag == req_tag);
        covers      = vld_q && (tag_q == req_tag) && !snp_hit_cur;
    end

    // Update the reservation on LR, SC and snoop hits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            tag_q <= '0;
        end else if (set) begin
            vld_q <= !snp_hit_new;
            tag_q <= req_tag;
        end else if (clear || snp_hit_cur) begin
            vld_q <= 1'b0;
        end
    end

endmodule

// File: rtl/lrsc_mem.sv
// Private word memory.
// One combinational read port and one synchronous write port.
// All words are cleared by reset.
module lrsc_mem #(
    parameter int WORDS = 16,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_word,
    input  logic          we,
    input  logic [IW-1:0] wr_idx,
    input  logic [31:0]   wr_word
);

    logic [31:0] store_q [WORDS];

    // Read the addressed word without delay
    always_comb rd_word = store_q[rd_idx];

    // Clear on reset, otherwise write one word when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) store_q[i] <= '0;
        end else if (we) begin
            store_q[wr_idx] <= wr_word;
        end
    end

endmodule

// File: rtl/lrsc_monitor.sv
// LR/SC reservation monitor, top level.
// Runs one word LR or SC per cycle against the private memory and
// registers the response one cycle later. Assumes the request
// address already holds the base-register value and that XLEN > 32.
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int WORDS      = 16,
    parameter int GRAN_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [31:0]                   req_insn,
    input  logic [$clog2(WORDS*4)-1:0]    req_addr,
    input  logic [31:0]                   req_wdata,
    input  logic                          snoop_valid,
    input  logic [$clog2(WORDS*4)-1:0]    snoop_addr,
    output logic                          rsp_valid,
    output logic [4:0]                    rsp_rd,
    output logic [XLEN-1:0]               rsp_data,
    output logic                          rsp_err
);

    localparam int AW  = $clog2(WORDS * 4);
    localparam int IW  = $clog2(WORDS);
    localparam int GL2 = $clog2(GRAN_BYTES);

    lrsc_op_e          op;
    logic              misaligned;
    logic              lr_go;
    logic              sc_go;
    logic              covers;
    logic              mem_we;
    logic              resv_vld;
    logic [AW-GL2-1:0] resv_tag;
    logic [31:0]       rd_word;
    logic [XLEN-1:0]   rsp_data_d;
    logic              rsp_err_d;

    lrsc_decode u_decode (
        .valid  (req_valid),
        .kind   (req_insn[31:27]),
        .src2   (req_insn[24:20]),
        .width  (req_insn[14:12]),
        .opcode (req_insn[6:0]),
        .op     (op)
    );

    lrsc_resv #(.AW(AW), .GL2(GL2)) u_resv (
        .clk         (clk),
        .rst_n       (rst_n),
        .set         (lr_go),
        .clear       (sc_go),
        .addr        (req_addr),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .covers      (covers),
        .vld_q       (resv_vld),
        .tag_q       (resv_tag)
    );

    lrsc_mem #(.WORDS(WORDS), .IW(IW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_addr[AW-1:2]),
        .rd_word (rd_word),
        .we      (mem_we),
        .wr_idx  (req_addr[AW-1:2]),
        .wr_word (req_wdata)
    );

    // Qualify operations by alignment and pick the response value
    always_comb begin
        misaligned = |req_addr[1:0];
        lr_go      = (op == OP_LR) && !misaligned;
        sc_go      = (op == OP_SC) && !misaligned;
        mem_we     = sc_go && covers;
        rsp_err_d  = (op == OP_BAD) || ((op != OP_NONE) && misaligned);
        rsp_data_d = '0;
        if (lr_go) begin
            rsp_data_d = {{(XLEN-32){rd_word[31]}}, rd_word};
        end else if (op == OP_SC) begin
            rsp_data_d = mem_we ? '0 : XLEN'(1);
        end
    end

    // Register the one-cycle response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rd    <= '0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= (op != OP_NONE);
            rsp_rd    <= req_insn[11:7];
            rsp_data  <= rsp_data_d;
            rsp_err   <= rsp_err_d;
        end
    end

endmodule

// File: rtl/lrsc_monitor_chk.sv
// Property checker for lrsc_monitor, attached by bind below.
// Watches ports plus the reservation, write-enable and go strobes.
module lrsc_monitor_chk #(
    parameter int AW  = 6,
    parameter int GL2 = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [AW-1:0]     req_addr,
    input logic              snoop_valid,
    input logic [AW-1:0]     snoop_addr,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              mem_we,
    input logic              lr_go,
    input logic              sc_go,
    input logic              resv_vld,
    input logic [AW-GL2-1:0] resv_tag
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R4
    commit_needs_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (resv_vld && resv_tag == req_addr[AW-1:GL2]));

    // R6
    sc_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_go |=> !resv_vld);

    // R7
    snoop_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && resv_vld && snoop_addr[AW-1:GL2] == resv_tag && !lr_go)
        |=> !resv_vld);

    // R8
    snoop_beats_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_go && snoop_valid && snoop_addr[AW-1:GL2] == req_addr[AW-1:GL2])
        |-> !mem_we);

    // R10
    misalign_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b00) |=> rsp_err);

    // R10
    misalign_keeps_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b00 && !snoop_valid)
        |=> ($stable(resv_vld) && $stable(resv_tag)));

endmodule

bind lrsc_monitor lrsc_monitor_chk #(.AW(AW), .GL2(GL2)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .mem_we      (mem_we),
    .lr_go       (lr_go),
    .sc_go       (sc_go),
    .resv_vld    (resv_vld),
    .resv_tag    (resv_tag)
);

// File: tb/tb_lrsc_monitor.sv
// Self-checking bench: directed corner cases plus seeded random mix,
// compared against a bench model of memory and reservation.
module tb_lrsc_monitor;

    localparam int XLEN  = 64;
    localparam int WORDS = 16;
    localparam int AW    = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [31:0]     req_insn = '0;
    logic [AW-1:0]   req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            snoop_valid = 1'b0;
    logic [AW-1:0]   snoop_addr = '0;
    logic            rsp_valid;
    logic [4:0]      rsp_rd;
    logic [XLEN-1:0] rsp_data;
    logic            rsp_err;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_mem [WORDS];
    bit          m_vld;
    int          m_tag;

    always #10 clk = ~clk;

    lrsc_monitor #(.XLEN(XLEN), .WORDS(WORDS), .GRAN_BYTES(8)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_insn(req_insn),
        .req_addr(req_addr), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .rsp_valid(rsp_valid), .rsp_rd(rsp_rd),
        .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    function automatic logic [31:0] mk(input logic [4:0] kind, input logic [4:0] src2,
                                       input logic [2:0] width, input logic [4:0] rd);
        return {kind, 2'b01, src2, 5'd9, width, rd, 7'b0101111};
    endfunction

    function automatic logic [31:0] lr_w(input logic [4:0] rd);
        return mk(5'b00010, 5'd0, 3'b010, rd);
    endfunction

    function automatic logic [31:0] sc_w(input logic [4:0] rd);
        return mk(5'b00011, 5'd6, 3'b010, rd);
    endfunction

    task automatic chk(input string req, input string what, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, update model, compare at next falling edge
    task automatic step(input string req, input bit v, input logic [31:0] insn,
                        input logic [AW-1:0] addr, input logic [31:0] wd,
                        input bit sv, input logic [AW-1:0] saddr);
        int kind;
        bit mis, hit_cur, win;
        logic [XLEN-1:0] e_data;
        bit e_err;
        req_valid = v; req_insn = insn; req_addr = addr; req_wdata = wd;
        snoop_valid = sv; snoop_addr = saddr;
        hit_cur = sv && m_vld && (int'(saddr >> 3) == m_tag);
        mis = addr[1:0] != 2'b00;
        kind = 3;
        if (insn[6:0] == 7'b0101111 && insn[14:12] == 3'b010) begin
            if (insn[31:27] == 5'b00010 && insn[24:20] == 5'd0) kind = 1;
            else if (insn[31:27] == 5'b00011) kind = 2;
        end
        e_data = '0; e_err = 1'b0;
        if (!v || kind == 3 || mis) begin
            if (v) begin
                e_err = 1'b1;
                e_data = (kind == 2) ? 64'd1 : 64'd0;
            end
            if (hit_cur) m_vld = 1'b0;
        end else if (kind == 1) begin
            e_data = {{32{m_mem[addr >> 2][31]}}, m_mem[addr >> 2]};
            m_vld = !(sv && (saddr >> 3) == (addr >> 3));
            m_tag = int'(addr >> 3);
        end else begin
            win = m_vld && (m_tag == int'(addr >> 3)) && !hit_cur;
            if (win) m_mem[addr >> 2] = wd;
            e_data = win ? 64'd0 : 64'd1;
            m_vld = 1'b0;
        end
        @(negedge clk);
        chk(req, "rsp_valid", XLEN'(rsp_valid), XLEN'(v));
        if (v) begin
            chk(req, "rsp_rd", XLEN'(rsp_rd), XLEN'(insn[11:7]));
            chk(req, "rsp_data", rsp_data, e_data);
            chk(req, "rsp_err", XLEN'(rsp_err), XLEN'(e_err));
        end
    endtask

    task automatic idle(input string req);
        step(req, 1'b0, '0, '0, '0, 1'b0, '0);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
        m_vld = 1'b0; m_tag = 0;
        repeat (3) @(negedge clk);
        // R11: response idle while in reset
        chk("R11", "rsp_valid in reset", XLEN'(rsp_valid), '0);
        rst_n = 1'b1;
        // R11: memory cleared, no reservation
        step("R11", 1'b1, lr_w(5'd1), 6'd0, '0, 1'b0, '0);
        step("R11", 1'b1, sc_w(5'd2), 6'd20, 32'h1, 1'b0, '0);
        // R5: SC without reservation
        step("R5", 1'b1, sc_w(5'd3), 6'd4, 32'h55, 1'b0, '0);
        step("R5", 1'b1, lr_w(5'd3), 6'd4, '0, 1'b0, '0);
        // R4, R3: commit to other word in granule, then sign-extended read
        step("R4", 1'b1, lr_w(5'd4), 6'd8, '0, 1'b0, '0);
        step("R4", 1'b1, sc_w(5'd5), 6'd12, 32'h8000_00F0, 1'b0, '0);
        step("R3", 1'b1, lr_w(5'd6), 6'd12, '0, 1'b0, '0);
        // R5: different granule
        step("R5", 1'b1, sc_w(5'd7), 6'd16, 32'h77, 1'b0, '0);
        // R6: second SC fails
        step("R6", 1'b1, lr_w(5'd8), 6'd16, '0, 1'b0, '0);
        step("R6", 1'b1, sc_w(5'd9), 6'd16, 32'h11, 1'b0, '0);
        step("R6", 1'b1, sc_w(5'd9), 6'd16, 32'h22, 1'b0, '0);
        // R7: snoop inside, then outside
        step("R7", 1'b1, lr_w(5'd10), 6'd24, '0, 1'b0, '0);
        step("R7", 1'b0, '0, '0, '0, 1'b1, 6'd28);
        step("R7", 1'b1, sc_w(5'd11), 6'd24, 32'h33, 1'b0, '0);
        step("R7", 1'b1, lr_w(5'd10), 6'd24, '0, 1'b0, '0);
        step("R7", 1'b0, '0, '0, '0, 1'b1, 6'd40);
        step("R7", 1'b1, sc_w(5'd11), 6'd24, 32'h44, 1'b0, '0);
        // R8: snoop races SC
        step("R8", 1'b1, lr_w(5'd12), 6'd32, '0, 1'b0, '0);
        step("R8", 1'b1, sc_w(5'd13), 6'd32, 32'h99, 1'b1, 6'd36);
        step("R8", 1'b1, lr_w(5'd12), 6'd32, '0, 1'b0, '0);
        // R9: new LR replaces old
        step("R9", 1'b1, lr_w(5'd14), 6'd0, '0, 1'b0, '0);
        step("R9", 1'b1, lr_w(5'd14), 6'd40, '0, 1'b0, '0);
        step("R9", 1'b1, sc_w(5'd15), 6'd0, 32'hAA, 1'b0, '0);
        // R10: misaligned keeps reservation
        step("R10", 1'b1, lr_w(5'd16), 6'd48, '0, 1'b0, '0);
        step("R10", 1'b1, sc_w(5'd17), 6'd50, 32'hBB, 1'b0, '0);
        step("R10", 1'b1, lr_w(5'd18), 6'd49, '0, 1'b0, '0);
        step("R10", 1'b1, sc_w(5'd17), 6'd48, 32'hCC, 1'b0, '0);
        // R1: malformed words leave the reservation
        step("R1", 1'b1, lr_w(5'd19), 6'd56, '0, 1'b0, '0);
        step("R1", 1'b1, mk(5'b00001, 5'd0, 3'b010, 5'd20), 6'd56, '0, 1'b0, '0);
        step("R1", 1'b1, mk(5'b00010, 5'd3, 3'b010, 5'd21), 6'd56, '0, 1'b0, '0);
        step("R1", 1'b1, mk(5'b00011, 5'd3, 3'b011, 5'd22), 6'd56, 32'hDD, 1'b0, '0);
        step("R1", 1'b1, sc_w(5'd23), 6'd60, 32'hEE, 1'b0, '0);
        // R12: snoop in LR cycle
        step("R12", 1'b1, lr_w(5'd24), 6'd16, '0, 1'b1, 6'd20);
        step("R12", 1'b1, sc_w(5'd25), 6'd16, 32'h12, 1'b0, '0);
        // R2: idle cycle
        idle("R2");
        // Random mix, mostly in the low granules
        for (int i = 0; i < 4000; i++) begin
            int sel;
            logic [31:0] insn;
            logic [AW-1:0] a;
            string tag;
            sel = $urandom_range(0, 99);
            if (sel < 44)      begin insn = lr_w(5'($urandom)); tag = "R3"; end
            else if (sel < 88) begin insn = sc_w(5'($urandom)); tag = "R4"; end
            else if (sel < 94) begin insn = mk(5'($urandom), 5'($urandom), 3'($urandom), 5'($urandom)); tag = "R1"; end
            else               begin insn = '0; tag = "R2"; end
            a = ($urandom_range(0, 9) == 0) ? AW'($urandom) : AW'({$urandom_range(0, 7), 2'b00});
            if (a[1:0] != 2'b00) tag = "R10";
            step(tag, sel < 94, insn, a, $urandom, $urandom_range(0, 4) == 0,
                 AW'($urandom_range(0, 31)));
        end
        idle("R2");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule